// File: doc/BRIEF.md
# Receive Path Power-Up Sequencer

This block brings a receive DSP path from its reset state to full operation in a fixed order, so that no software has to pace the steps. A single start request captures the channel-filter settings (decimation and bandwidth code), the demodulator setting and the clock-divider choice. The block then walks through a fixed chain of steps. It applies the configuration, sets the optional divider enable and switches DSP power on. It waits for the supply to settle and enables the receive path. It lets the channel filter out of hold and waits for the filter to settle. Last, it lets every demodulator out of hold and reports ready.

The supply wait is given in picoseconds and turned into whole clock cycles, rounded up, from the clock-period parameter. The filter settling wait is a plain cycle count. A synchronous abort input, or the asynchronous reset, puts every control output back to its safe value from any step: power off, path disabled, filter and demodulators held, configuration cleared. All pins are plain control and status levels. There is no data stream and no handshake.

Top module: `rxpu_sequencer`

## Requirements
- R1: While reset is asserted, every control output takes its safe value: dsp_pwr_o, rx_en_o, clkdiv_en_o, ready_o and busy_o are 0, filt_hold_o and every demod_hold_o bit are 1, and filt_decim_o, filt_bw_o and demod_cfg_o are 0.
- R2: A start seen while idle captures cfg_decim_i, cfg_bw_i and cfg_demod_i onto filt_decim_o, filt_bw_o and demod_cfg_o at that same clock edge, and busy_o rises at that edge. The captured values stay unchanged until an abort.
- R3: clkdiv_en_o is set one edge after the capture edge if cfg_clkdiv_i was 1 at capture, and it stays 0 otherwise. It is therefore settled before power comes on.
- R4: dsp_pwr_o rises two edges after the capture edge. rx_en_o rises SUP_CYC edges later, where SUP_CYC = ceil(SUPPLY_WAIT_PS / CLK_PERIOD_PS), with a minimum of 1.
- R5: filt_hold_o falls one edge after rx_en_o rises.
- R6: All demod_hold_o bits fall together FILT_SETTLE_CYC + 1 edges after filt_hold_o falls.
- R7: ready_o rises one edge after the demodulators are released and then holds. busy_o is 1 in every non-idle step before ready. The two are never 1 together.
- R8: A start request while the sequence is running or ready has no effect: the step timing and the captured configuration are unchanged.
- R9: An abort returns every output to its R1 value at the next edge, from any step. An abort in the same cycle as a start wins, and the block stays idle.
- R10: At all times the steps are ordered: rx_en_o implies dsp_pwr_o, a released filter implies rx_en_o, and a released demodulator implies a released filter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to start the power-up chain (level sampled each edge) |
| abort_i | input | 1 | Synchronous return to idle and safe outputs |
| cfg_decim_i | input | DEC_W | Channel-filter decimation code to apply |
| cfg_bw_i | input | BW_W | Channel-filter bandwidth code to apply |
| cfg_demod_i | input | DEM_W | Demodulator setting to apply |
| cfg_clkdiv_i | input | 1 | 1 selects the clock divider enable |
| filt_decim_o | output | DEC_W | Applied decimation code |
| filt_bw_o | output | BW_W | Applied bandwidth code |
| demod_cfg_o | output | DEM_W | Applied demodulator setting |
| clkdiv_en_o | output | 1 | Clock divider enable |
| dsp_pwr_o | output | 1 | DSP power enable |
| rx_en_o | output | 1 | Receive path enable |
| filt_hold_o | output | 1 | 1 holds the channel filter in preset |
| demod_hold_o | output | NUM_DEMOD | 1 per bit holds that demodulator in preset |
| ready_o | output | 1 | Path is operational |
| busy_o | output | 1 | Sequence in progress |

## Verification
Two cases can land on one clock edge. A start can arrive together with an abort, and a new start can arrive while an earlier sequence is still counting or already ready. The bench drives a directed start-with-abort from idle. Its random runs scatter extra start pulses, carrying fresh configuration values, through every step and place aborts at random steps, sometimes in the same cycle as one of those starts. A cycle model in the bench decides each outcome: the abort must win, and an ignored start must leave both the step timing and the captured configuration untouched.

// File: rtl/rxpu_pkg.sv
package rxpu_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CFG,
    ST_DIV,
    ST_PWR,
    ST_RXEN,
    ST_FREL,
    ST_FSET,
    ST_DREL,
    ST_RDY
  } rxpu_state_e;

  function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction

  function automatic int unsigned at_least_one(input int unsigned v);
    return (v == 0) ? 1 : v;
  endfunction

endpackage

// File: rtl/rxpu_wait_timer.sv
module rxpu_wait_timer #(
  parameter int unsigned LEN = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);

  localparam int unsigned CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] cnt_q;

  // Counts the cycles spent in the waiting step; restarts at zero whenever idle.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (run_i && (cnt_q != LAST)) begin
      cnt_q <= cnt_q + 1'b1;
    end else begin
      cnt_q <= '0;
    end
  end

  assign done_o = run_i && (cnt_q == LAST);

  AST_WAIT_FRESH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_i) |-> (cnt_q == '0)); // R4

  AST_WAIT_HOLDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !done_o) |=> (cnt_q != '0) || !run_i); // R6

endmodule

// File: rtl/rxpu_cfg_latch.sv
module rxpu_cfg_latch #(
  parameter int unsigned DEC_W = 3,
  parameter int unsigned BW_W  = 2,
  parameter int unsigned DEM_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             clear_i,
  input  logic [DEC_W-1:0] decim_i,
  input  logic [BW_W-1:0]  bw_i,
  input  logic [DEM_W-1:0] demod_i,
  input  logic             div_i,
  output logic [DEC_W-1:0] decim_o,
  output logic [BW_W-1:0]  bw_o,
  output logic [DEM_W-1:0] demod_o,
  output logic             div_o
);

  // Clear has priority: an abort in the same cycle as a start leaves nothing applied.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      decim_o <= '0;
      bw_o    <= '0;
      demod_o <= '0;
      div_o   <= 1'b0;
    end else if (clear_i) begin
      decim_o <= '0;
      bw_o    <= '0;
      demod_o <= '0;
      div_o   <= 1'b0;
    end else if (load_i) begin
      decim_o <= decim_i;
      bw_o    <= bw_i;
      demod_o <= demod_i;
      div_o   <= div_i;
    end
  end

  AST_CLEAR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (decim_o == '0) && (bw_o == '0) && (demod_o == '0) && !div_o); // R9

endmodule

// File: rtl/rxpu_ctrl_fsm.sv
module rxpu_ctrl_fsm
  import rxpu_pkg::*;
#(
  parameter int unsigned NUM_DEMOD = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 abort_i,
  input  logic                 sup_done_i,
  input  logic                 filt_done_i,
  input  logic                 div_sel_i,
  output logic                 load_o,
  output logic                 sup_run_o,
  output logic                 filt_run_o,
  output logic                 clkdiv_en_o,
  output logic                 dsp_pwr_o,
  output logic                 rx_en_o,
  output logic                 filt_hold_o,
  output logic [NUM_DEMOD-1:0] demod_hold_o,
  output logic                 ready_o,
  output logic                 busy_o
);

  rxpu_state_e state_q, state_d;
  logic        dem_hold;

  assign load_o     = (state_q == ST_IDLE) && start_i && !abort_i;
  assign sup_run_o  = (state_q == ST_PWR);
  assign filt_run_o = (state_q == ST_FSET);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_CFG;
      ST_CFG:  state_d = ST_DIV;
      ST_DIV:  state_d = ST_PWR;
      ST_PWR:  if (sup_done_i) state_d = ST_RXEN;
      ST_RXEN: state_d = ST_FREL;
      ST_FREL: state_d = ST_FSET;
      ST_FSET: if (filt_done_i) state_d = ST_DREL;
      ST_DREL: state_d = ST_RDY;
      ST_RDY:  state_d = ST_RDY;
      default: state_d = ST_IDLE;
    endcase
    if (abort_i) state_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // Moore decode: each step keeps everything the earlier steps switched on.
  always_comb begin
    clkdiv_en_o = 1'b0;
    dsp_pwr_o   = 1'b0;
    rx_en_o     = 1'b0;
    filt_hold_o = 1'b1;
    dem_hold    = 1'b1;
    ready_o     = 1'b0;
    busy_o      = 1'b1;
    unique case (state_q)
      ST_IDLE: busy_o = 1'b0;
      ST_CFG:  ;
      ST_DIV:  clkdiv_en_o = div_sel_i;
      ST_PWR, ST_RXEN: begin
        clkdiv_en_o = div_sel_i;
        dsp_pwr_o   = 1'b1;
        rx_en_o     = (state_q == ST_RXEN);
      end
      ST_FREL, ST_FSET: begin
        clkdiv_en_o = div_sel_i;
        dsp_pwr_o   = 1'b1;
        rx_en_o     = 1'b1;
        filt_hold_o = 1'b0;
      end
      ST_DREL, ST_RDY: begin
        clkdiv_en_o = div_sel_i;
        dsp_pwr_o   = 1'b1;
        rx_en_o     = 1'b1;
        filt_hold_o = 1'b0;
        dem_hold    = 1'b0;
        ready_o     = (state_q == ST_RDY);
        busy_o      = (state_q != ST_RDY);
      end
      default: busy_o = 1'b0;
    endcase
  end

  for (genvar g = 0; g < NUM_DEMOD; g++) begin : g_dem
    assign demod_hold_o[g] = dem_hold;
  end

  AST_ABORT_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (state_q == ST_IDLE)); // R9

  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && start_i && !abort_i) |=> (state_q != ST_CFG)); // R8

  AST_READY_STICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !abort_i) |=> ready_o); // R7

  AST_READY_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ready_o && busy_o)); // R7

  AST_PWR_AFTER_DIV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dsp_pwr_o) |-> ($past(state_q) == ST_DIV)); // R3

endmodule

// File: rtl/rxpu_sequencer.sv
module rxpu_sequencer
  import rxpu_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS   = 8000,
  parameter int unsigned SUPPLY_WAIT_PS  = 200000,
  parameter int unsigned FILT_SETTLE_CYC = 40,
  parameter int unsigned NUM_DEMOD       = 2,
  parameter int unsigned DEC_W           = 3,
  parameter int unsigned BW_W            = 2,
  parameter int unsigned DEM_W           = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 abort_i,
  input  logic [DEC_W-1:0]     cfg_decim_i,
  input  logic [BW_W-1:0]      cfg_bw_i,
  input  logic [DEM_W-1:0]     cfg_demod_i,
  input  logic                 cfg_clkdiv_i,
  output logic [DEC_W-1:0]     filt_decim_o,
  output logic [BW_W-1:0]      filt_bw_o,
  output logic [DEM_W-1:0]     demod_cfg_o,
  output logic                 clkdiv_en_o,
  output logic                 dsp_pwr_o,
  output logic                 rx_en_o,
  output logic                 filt_hold_o,
  output logic [NUM_DEMOD-1:0] demod_hold_o,
  output logic                 ready_o,
  output logic                 busy_o
);

  localparam int unsigned SUP_CYC  = at_least_one(ceil_div(SUPPLY_WAIT_PS, CLK_PERIOD_PS));
  localparam int unsigned FILT_CYC = at_least_one(FILT_SETTLE_CYC);

  logic load, sup_run, filt_run, sup_done, filt_done, div_sel;

  rxpu_cfg_latch #(
    .DEC_W (DEC_W),
    .BW_W  (BW_W),
    .DEM_W (DEM_W)
  ) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .clear_i (abort_i),
    .decim_i (cfg_decim_i),
    .bw_i    (cfg_bw_i),
    .demod_i (cfg_demod_i),
    .div_i   (cfg_clkdiv_i),
    .decim_o (filt_decim_o),
    .bw_o    (filt_bw_o),
    .demod_o (demod_cfg_o),
    .div_o   (div_sel)
  );

  rxpu_wait_timer #(.LEN(SUP_CYC)) u_sup_wait (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (sup_run),
    .done_o (sup_done)
  );

  rxpu_wait_timer #(.LEN(FILT_CYC)) u_filt_wait (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (filt_run),
    .done_o (filt_done)
  );

  rxpu_ctrl_fsm #(.NUM_DEMOD(NUM_DEMOD)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .abort_i      (abort_i),
    .sup_done_i   (sup_done),
    .filt_done_i  (filt_done),
    .div_sel_i    (div_sel),
    .load_o       (load),
    .sup_run_o    (sup_run),
    .filt_run_o   (filt_run),
    .clkdiv_en_o  (clkdiv_en_o),
    .dsp_pwr_o    (dsp_pwr_o),
    .rx_en_o      (rx_en_o),
    .filt_hold_o  (filt_hold_o),
    .demod_hold_o (demod_hold_o),
    .ready_o      (ready_o),
    .busy_o       (busy_o)
  );

  AST_CFG_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((busy_o || ready_o) && !abort_i) |=>
      ($stable(filt_decim_o) && $stable(filt_bw_o) && $stable(demod_cfg_o))); // R2

  AST_EN_AFTER_PWR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_en_o) |-> $past(dsp_pwr_o)); // R4

  AST_FILT_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !filt_hold_o |-> rx_en_o && dsp_pwr_o); // R10

  AST_DEM_NEEDS_FILT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (demod_hold_o != {NUM_DEMOD{1'b1}}) |-> !filt_hold_o); // R10

  AST_DEM_AFTER_SETTLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(demod_hold_o[0]) |-> $past(filt_done)); // R6

endmodule

// File: tb/rxpu_sequencer_test.sv
`timescale 1ns/1ps
module rxpu_sequencer_test;

  localparam int unsigned CLK_PS = 8000;
  localparam int unsigned SUP_PS = 200000;
  localparam int unsigned FILT   = 40;
  localparam int unsigned NDEM   = 2;
  localparam int unsigned DEC_W  = 3;
  localparam int unsigned BW_W   = 2;
  localparam int unsigned DEM_W  = 6;
  localparam int S      = (SUP_PS + CLK_PS - 1) / CLK_PS;
  localparam int RDY_N  = 6 + S + FILT;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, abort_i = 1'b0, cfg_clkdiv_i = 1'b0;
  logic [DEC_W-1:0] cfg_decim_i = '0;
  logic [BW_W-1:0]  cfg_bw_i = '0;
  logic [DEM_W-1:0] cfg_demod_i = '0;
  logic [DEC_W-1:0] filt_decim_o;
  logic [BW_W-1:0]  filt_bw_o;
  logic [DEM_W-1:0] demod_cfg_o;
  logic clkdiv_en_o, dsp_pwr_o, rx_en_o, filt_hold_o, ready_o, busy_o;
  logic [NDEM-1:0] demod_hold_o;

  always #4 clk = ~clk;

  rxpu_sequencer #(
    .CLK_PERIOD_PS(CLK_PS), .SUPPLY_WAIT_PS(SUP_PS), .FILT_SETTLE_CYC(FILT),
    .NUM_DEMOD(NDEM), .DEC_W(DEC_W), .BW_W(BW_W), .DEM_W(DEM_W)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .abort_i(abort_i),
    .cfg_decim_i(cfg_decim_i), .cfg_bw_i(cfg_bw_i), .cfg_demod_i(cfg_demod_i),
    .cfg_clkdiv_i(cfg_clkdiv_i), .filt_decim_o(filt_decim_o), .filt_bw_o(filt_bw_o),
    .demod_cfg_o(demod_cfg_o), .clkdiv_en_o(clkdiv_en_o), .dsp_pwr_o(dsp_pwr_o),
    .rx_en_o(rx_en_o), .filt_hold_o(filt_hold_o), .demod_hold_o(demod_hold_o),
    .ready_o(ready_o), .busy_o(busy_o)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Bench model: n counts edges since the capture edge (0 = idle).
  int n = 0;
  logic [DEC_W-1:0] m_dec = '0;
  logic [BW_W-1:0]  m_bw = '0;
  logic [DEM_W-1:0] m_dem = '0;
  logic             m_div = 1'b0;
  string ov = "";

  function automatic string tg(input string dflt);
    return (ov != "") ? ov : dflt;
  endfunction

  task automatic chk(input string req, input string name, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h (n=%0d)", req, name, act, exp, n);
    end
  endtask

  task automatic check_all();
    chk(tg("R2"), "filt_decim", 32'(filt_decim_o), 32'(m_dec));
    chk(tg("R2"), "filt_bw", 32'(filt_bw_o), 32'(m_bw));
    chk(tg("R2"), "demod_cfg", 32'(demod_cfg_o), 32'(m_dem));
    chk(tg("R3"), "clkdiv_en", 32'(clkdiv_en_o), 32'(n >= 2 && m_div));
    chk(tg("R4"), "dsp_pwr", 32'(dsp_pwr_o), 32'(n >= 3));
    chk(tg("R4"), "rx_en", 32'(rx_en_o), 32'(n >= 3 + S));
    chk(tg("R5"), "filt_hold", 32'(filt_hold_o), 32'(n < 4 + S));
    chk(tg("R6"), "demod_hold", 32'(demod_hold_o), (n < 5 + S + FILT) ? 32'((1 << NDEM) - 1) : 32'd0);
    chk(tg("R7"), "ready", 32'(ready_o), 32'(n >= RDY_N));
    chk(tg("R7"), "busy", 32'(busy_o), 32'(n >= 1 && n < RDY_N));
    chk("R10", "order", 32'((rx_en_o && !dsp_pwr_o) || (!filt_hold_o && !rx_en_o) ||
                            (!demod_hold_o[0] && filt_hold_o)), 32'd0);
  endtask

  // Called at a falling edge: drive, advance the model across the next rising edge, check.
  task automatic step(input logic st, input logic ab);
    logic [DEC_W-1:0] d;
    logic [BW_W-1:0]  b;
    logic [DEM_W-1:0] m;
    logic             v;
    d = DEC_W'($urandom); b = BW_W'($urandom); m = DEM_W'($urandom); v = 1'($urandom);
    cfg_decim_i = d; cfg_bw_i = b; cfg_demod_i = m; cfg_clkdiv_i = v;
    start_i = st; abort_i = ab;
    ov = "";
    if (ab) begin
      n = 0; m_dec = '0; m_bw = '0; m_dem = '0; m_div = 1'b0; ov = "R9";
    end else if (n == 0) begin
      if (st) begin n = 1; m_dec = d; m_bw = b; m_dem = m; m_div = v; end
    end else begin
      if (st) ov = "R8";
      if (n < RDY_N) n++;
    end
    @(negedge clk);
    check_all();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    ov = "R1";
    check_all();
    rst_n = 1'b1;
    ov = "";

    // R9: start and abort in the same cycle from idle stays idle.
    step(1'b1, 1'b1);
    step(1'b0, 1'b0);

    // R3/R4/R5/R6/R7: full sequence, then R8 start ignored in ready, then R9 abort.
    step(1'b1, 1'b0);
    for (int c = 0; c < RDY_N + 3; c++) step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b1);
    step(1'b0, 1'b0);

    // Random runs with stray starts and randomly placed aborts.
    for (int r = 0; r < 30; r++) begin
      int abort_at;
      abort_at = int'($urandom % (RDY_N + 15));
      step(1'b1, 1'b0);
      for (int c = 0; c < RDY_N + 4; c++) begin
        step(($urandom % 6) == 0, c == abort_at);
      end
      step(($urandom % 2) == 0, 1'b1);
      for (int c = 0; c < int'($urandom % 4); c++) step(1'b0, 1'b0);
    end

    finish_run();
  end

endmodule